// File: doc/BRIEF.md
# Suspend and Wake-Up Controller

This block sequences a microcontroller into and out of its low-power suspend state. Firmware requests suspend with a one-cycle pulse that sets the suspend status bit. On the next clock edge the controller withdraws the enables for the main oscillator, the free-running timer and the watchdog, and holds the CPU. It also hands voltage supervision from the main low-voltage monitor to the brown-out detector. Only the interrupt inputs, the D- data-line receiver and an optional slow wake timer stay live.

Suspend ends on one of three events: a pending interrupt whose enable is set, the D- line held low for two consecutive synchronized samples, or an expiry tick from the wake timer. On wake the suspend bit clears and all clock enables return at once. The CPU is released only after a programmable settle interval. A watchdog reset clears the external-oscillator select held in configuration. The clock source actually in use follows that select only at the moment suspend is next entered.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset the controller is running: `susp_bit`=0, `osc_en`=`frt_en`=`wdt_en`=1, `cpu_run`=1, `xosc_active`=0, `wtmr_tick`=0.
- R2: A `susp_set` pulse while running makes `susp_bit`=1 and `osc_en`=`frt_en`=`wdt_en`=`cpu_run`=0 from the next clock edge until a wake event.
- R3: While suspended `lvr_active`=0 and `bor_active`=1. At all other times `lvr_active` equals `lvr_en_cfg` and `bor_active` is its inverse.
- R4: While suspended, a bit set in both `irq_req` and `irq_en` wakes the device at the next edge. An interrupt whose enable bit is 0 does not wake it.
- R5: On wake, `susp_bit` clears and the three clock enables return to 1 at the wake edge. `cpu_run` returns to 1 exactly WAKE_SETTLE (default 2) edges later.
- R6: `dminus_pin` passes through a two-flop synchronizer. A low level wakes the device only after two consecutive synchronized low samples. A pin driven low before edge a clears `susp_bit` at edge a+3. A low lasting a single cycle never wakes the device.
- R7: With `wtmr_en`=1 the wake timer pulses `wtmr_tick` for one cycle every WT_PERIOD (default 16) cycles. The first pulse comes WT_PERIOD edges after the enable is seen. With `wtmr_en`=0 the timer is held cleared. A tick during suspend wakes the device at the following edge.
- R8: `xosc_wr` loads `xosc_wr_val` into the oscillator-select configuration and `wdr_pulse` clears it; `wdr_pulse` has priority. `xosc_active` copies the configuration only at the edge that enters suspend and is otherwise unchanged.
- R9: `susp_set` has no effect while suspended or during the wake settle interval.
- R10: `cpu_run`=1 always implies `osc_en`=`frt_en`=`wdt_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| susp_set | input | 1 | Firmware pulse that sets the suspend bit |
| irq_req | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| dminus_pin | input | 1 | Asynchronous D- data-line level |
| wtmr_en | input | 1 | Wake timer enable |
| lvr_en_cfg | input | 1 | Main low-voltage monitor enabled by firmware |
| xosc_wr | input | 1 | Write strobe for oscillator-select configuration |
| xosc_wr_val | input | 1 | Value written; 1 selects external oscillator |
| wdr_pulse | input | 1 | Watchdog reset event |
| susp_bit | output | 1 | Suspend status bit |
| osc_en | output | 1 | Oscillator enable |
| frt_en | output | 1 | Free-running timer clock enable |
| wdt_en | output | 1 | Watchdog timer clock enable |
| cpu_run | output | 1 | CPU released |
| lvr_active | output | 1 | Main low-voltage monitor active |
| bor_active | output | 1 | Brown-out detector active |
| wtmr_tick | output | 1 | Wake timer expiry pulse |
| xosc_active | output | 1 | Clock source in use is external |

## Verification
The bench covers a D- low that lasts exactly one cycle. A filter that trusted a single sample would wake on that glitch. It times the CPU release against the return of the clock enables, which catches a design that frees the CPU in the same cycle or one too early. It applies a watchdog reset while running, where a design applying the clear at once would change `xosc_active` before the next suspend entry. It also pulses `susp_set` during suspend and during the settle interval, where a careless state machine would fall back asleep. Disabled interrupts, the monitor hand-over and the exact period of the wake timer are each checked at the cycle where they must show.

// File: rtl/susp_pkg.sv
package susp_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_WAKE  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/dm_wake_filter.sv
// Synchronizes the D- level and reports a low seen on two consecutive samples.
module dm_wake_filter #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic low_seen
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign low_seen = ~sync_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/wake_tick_gen.sv
// Slow periodic wake timer: one-cycle tick every PERIOD cycles while enabled.
module wake_tick_gen #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    cnt_d  = '0;
    tick_d = 1'b0;
    if (en) begin
      if (cnt_q == LAST) begin
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
  import susp_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int WT_PERIOD   = 16,
  parameter int WAKE_SETTLE = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             susp_set,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             dminus_pin,
  input  logic             wtmr_en,
  input  logic             lvr_en_cfg,
  input  logic             xosc_wr,
  input  logic             xosc_wr_val,
  input  logic             wdr_pulse,
  output logic             susp_bit,
  output logic             osc_en,
  output logic             frt_en,
  output logic             wdt_en,
  output logic             cpu_run,
  output logic             lvr_active,
  output logic             bor_active,
  output logic             wtmr_tick,
  output logic             xosc_active
);
  localparam int SW = $clog2(WAKE_SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(WAKE_SETTLE - 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Wake sources
  logic dm_low;
  logic irq_wake;
  logic wake_any;

  dm_wake_filter #(.STAGES(SYNC_STAGES)) u_dm_filt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin      (dminus_pin),
    .low_seen (dm_low)
  );

  wake_tick_gen #(.PERIOD(WT_PERIOD)) u_wtmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (wtmr_en),
    .tick  (wtmr_tick)
  );

  assign irq_wake = |(irq_req & irq_en);
  assign wake_any = irq_wake | dm_low | wtmr_tick;

  // State
  pwr_state_e    state_q, state_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          xosc_cfg_q, xosc_cfg_d;
  logic          xosc_act_q, xosc_act_d;
  logic          xosc_act_load;

  always_comb begin
    state_d       = state_q;
    settle_d      = settle_q;
    xosc_act_load = 1'b0;
    unique case (state_q)
      PS_RUN: begin
        if (susp_set) begin
          state_d       = PS_SLEEP;
          xosc_act_load = 1'b1;
        end
      end
      PS_SLEEP: begin
        if (wake_any) begin
          state_d  = PS_WAKE;
          settle_d = '0;
        end
      end
      PS_WAKE: begin
        if (settle_q == SETTLE_LAST) state_d = PS_RUN;
        else                         settle_d = settle_q + 1'b1;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_comb begin
    xosc_cfg_d = xosc_cfg_q;
    if (wdr_pulse)    xosc_cfg_d = 1'b0;
    else if (xosc_wr) xosc_cfg_d = xosc_wr_val;
    xosc_act_d = xosc_act_load ? xosc_cfg_q : xosc_act_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= PS_RUN;
      settle_q   <= '0;
      xosc_cfg_q <= 1'b0;
      xosc_act_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      settle_q   <= settle_d;
      xosc_cfg_q <= xosc_cfg_d;
      xosc_act_q <= xosc_act_d;
    end
  end

  // Outputs decoded from the registered state
  assign susp_bit    = (state_q == PS_SLEEP);
  assign osc_en      = ~susp_bit;
  assign frt_en      = ~susp_bit;
  assign wdt_en      = ~susp_bit;
  assign cpu_run     = (state_q == PS_RUN);
  assign lvr_active  = lvr_en_cfg & ~susp_bit;
  assign bor_active  = ~lvr_active;
  assign xosc_active = xosc_act_q;
endmodule

// File: rtl/susp_wake_chk.sv
module susp_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic susp_set,
  input logic lvr_en_cfg,
  input logic susp_bit,
  input logic osc_en,
  input logic frt_en,
  input logic wdt_en,
  input logic cpu_run,
  input logic lvr_active,
  input logic bor_active,
  input logic xosc_active
);
  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && susp_set) |=> susp_bit);

  assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    susp_bit |-> (!osc_en && !frt_en && !wdt_en && !cpu_run));

  assert_monitor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    susp_bit |-> (bor_active && !lvr_active));

  assert_monitor_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !susp_bit |-> (lvr_active == lvr_en_cfg));

  assert_wake_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_bit) |-> (osc_en && !cpu_run));

  assert_xosc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_run && susp_set) |=> $stable(xosc_active));

  assert_clk_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (osc_en && frt_en && wdt_en));
endmodule

bind susp_wake_ctrl susp_wake_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .susp_set    (susp_set),
  .lvr_en_cfg  (lvr_en_cfg),
  .susp_bit    (susp_bit),
  .osc_en      (osc_en),
  .frt_en      (frt_en),
  .wdt_en      (wdt_en),
  .cpu_run     (cpu_run),
  .lvr_active  (lvr_active),
  .bor_active  (bor_active),
  .xosc_active (xosc_active)
);

// File: tb/tb_susp_wake_ctrl.sv
`timescale 1ns/1ps
module tb_susp_wake_ctrl;
  localparam int NI = 8;
  localparam int WP = 16;
  localparam int WS = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic susp_set, dminus_pin, wtmr_en, lvr_en_cfg, xosc_wr, xosc_wr_val, wdr_pulse;
  logic [NI-1:0] irq_req, irq_en;
  logic susp_bit, osc_en, frt_en, wdt_en, cpu_run, lvr_active, bor_active, wtmr_tick, xosc_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  susp_wake_ctrl #(.N_IRQ(NI), .WT_PERIOD(WP), .WAKE_SETTLE(WS)) dut (
    .clk(clk), .rst_n(rst_n), .susp_set(susp_set), .irq_req(irq_req), .irq_en(irq_en),
    .dminus_pin(dminus_pin), .wtmr_en(wtmr_en), .lvr_en_cfg(lvr_en_cfg),
    .xosc_wr(xosc_wr), .xosc_wr_val(xosc_wr_val), .wdr_pulse(wdr_pulse),
    .susp_bit(susp_bit), .osc_en(osc_en), .frt_en(frt_en), .wdt_en(wdt_en),
    .cpu_run(cpu_run), .lvr_active(lvr_active), .bor_active(bor_active),
    .wtmr_tick(wtmr_tick), .xosc_active(xosc_active)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic enter_suspend();
    susp_set = 1'b1;
    step(1);
    susp_set = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 susp_bit", susp_bit, 1'b0);
    chk("R1 clocks", osc_en & frt_en & wdt_en, 1'b1);
    chk("R1 cpu_run", cpu_run, 1'b1);
    chk("R1 xosc_active", xosc_active, 1'b0);
    chk("R1 wtmr_tick", wtmr_tick, 1'b0);
  endtask

  task automatic t_enter();
    lvr_en_cfg = 1'b1;
    step(1);
    chk("R3 run lvr", lvr_active, 1'b1);
    chk("R3 run bor", bor_active, 1'b0);
    enter_suspend();
    chk("R2 susp_bit", susp_bit, 1'b1);
    chk("R2 osc_en", osc_en, 1'b0);
    chk("R2 frt_en", frt_en, 1'b0);
    chk("R2 wdt_en", wdt_en, 1'b0);
    chk("R2 cpu_run", cpu_run, 1'b0);
    chk("R3 sleep lvr", lvr_active, 1'b0);
    chk("R3 sleep bor", bor_active, 1'b1);
    step(5);
    chk("R2 stays asleep", susp_bit, 1'b1);
  endtask

  task automatic t_irq_wake();
    irq_req = 8'h04; irq_en = 8'hFB;
    step(3);
    chk("R4 disabled irq ignored", susp_bit, 1'b1);
    irq_en = 8'h04;
    step(1);
    irq_req = '0; irq_en = '0;
    chk("R5 susp cleared", susp_bit, 1'b0);
    chk("R5 clocks back", osc_en & frt_en & wdt_en, 1'b1);
    chk("R5 cpu held", cpu_run, 1'b0);
    chk("R3 lvr back", lvr_active, 1'b1);
    step(WS - 1);
    chk("R5 cpu held before settle", cpu_run, 1'b0);
    step(1);
    chk("R5 cpu released", cpu_run, 1'b1);
  endtask

  task automatic t_ignore_set();
    enter_suspend();
    enter_suspend();
    chk("R9 set in sleep", susp_bit, 1'b1);
    irq_req = 8'h01; irq_en = 8'h01;
    step(1);
    irq_req = '0; irq_en = '0;
    susp_set = 1'b1;
    step(1);
    susp_set = 1'b0;
    chk("R9 set in settle", susp_bit, 1'b0);
    step(1);
    chk("R9 run after settle", cpu_run, 1'b1);
    chk("R9 not asleep", susp_bit, 1'b0);
  endtask

  task automatic t_dminus();
    enter_suspend();
    dminus_pin = 1'b0;
    step(1);
    dminus_pin = 1'b1;
    step(6);
    chk("R6 glitch ignored", susp_bit, 1'b1);
    dminus_pin = 1'b0;
    step(3);
    chk("R6 not yet at a+2", susp_bit, 1'b1);
    step(1);
    chk("R6 wake at a+3", susp_bit, 1'b0);
    dminus_pin = 1'b1;
    step(WS + 3);
    chk("R6 running", cpu_run, 1'b1);
  endtask

  task automatic t_timer();
    wtmr_en = 1'b1;
    step(WP - 1);
    chk("R7 no early tick", wtmr_tick, 1'b0);
    step(1);
    chk("R7 first tick", wtmr_tick, 1'b1);
    step(1);
    chk("R7 tick one cycle", wtmr_tick, 1'b0);
    step(WP - 2);
    chk("R7 period no tick", wtmr_tick, 1'b0);
    enter_suspend();
    chk("R7 second tick", wtmr_tick, 1'b1);
    chk("R7 asleep at tick", susp_bit, 1'b1);
    step(1);
    chk("R7 tick wakes", susp_bit, 1'b0);
    wtmr_en = 1'b0;
    step(WP * 2 + 2);
    chk("R7 disabled no tick", wtmr_tick, 1'b0);
    chk("R7 running", cpu_run, 1'b1);
  endtask

  task automatic t_xosc();
    xosc_wr = 1'b1; xosc_wr_val = 1'b1;
    step(1);
    xosc_wr = 1'b0;
    step(2);
    chk("R8 not applied while run", xosc_active, 1'b0);
    enter_suspend();
    chk("R8 applied at entry", xosc_active, 1'b1);
    irq_req = 8'h80; irq_en = 8'h80;
    step(1);
    irq_req = '0; irq_en = '0;
    step(WS + 1);
    wdr_pulse = 1'b1;
    step(1);
    wdr_pulse = 1'b0;
    step(3);
    chk("R8 wdr deferred", xosc_active, 1'b1);
    lvr_en_cfg = 1'b0;
    step(1);
    chk("R3 lvr disabled run", bor_active, 1'b1);
    enter_suspend();
    chk("R8 cleared at entry", xosc_active, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; susp_set = 1'b0; dminus_pin = 1'b1; wtmr_en = 1'b0;
    lvr_en_cfg = 1'b0; xosc_wr = 1'b0; xosc_wr_val = 1'b0; wdr_pulse = 1'b0;
    irq_req = '0; irq_en = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_enter();
    t_irq_wake();
    t_ignore_set();
    t_dminus();
    t_timer();
    t_xosc();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule